// File: doc/BRIEF.md
# Module Status LED Controller

This block decides what a bicolor front-panel status lamp shows. The lamp has a red element and a green element, and amber is shown by lighting both. Four status inputs feed the block: a flag that the driver has brought the module up, a one-cycle strobe for each register access, an over-temperature flag, and a hardware-fault flag. The block ranks these conditions and drives the lamp for the one with the highest rank. It stretches each access strobe into an amber flash long enough to see, and it makes the blink pattern for over-temperature.

A second lamp, the identify lamp, turns amber while a software-controlled request bit is set and is dark when the bit is clear. This lamp does not depend on any of the status conditions. All timing comes from a millisecond tick, which a prescaler makes from the single system clock. A parameter gives the number of clock cycles in one millisecond. Both lamps are registered, so each one follows its inputs one clock later.

Top module: `status_led_ctrl`

## Requirements
- R1: While reset is asserted, and in the first sampled cycle after it, all four lamp outputs are 0.
- R2: With the ready flag low and no access, over-temperature or fault, the status lamp is dark (red 0, green 0).
- R3: With the ready flag high and no other condition, the status lamp is steady green (red 0, green 1).
- R4: An access strobe shows amber (red 1, green 1) from the clock edge that samples it. The amber holds until FLASH_MS millisecond ticks have passed with no further strobe.
- R5: A strobe that arrives during a flash reloads the full FLASH_MS window.
- R6: While over-temperature is high and no fault is present, green is 0 and red blinks at a 50% duty cycle. Red is lit for the first BLINK_HALF_MS ticks and dark for the next BLINK_HALF_MS ticks, and the pattern restarts lit each time the flag rises.
- R7: While the fault flag is high, the status lamp is steady red (red 1, green 0), whatever the other inputs are.
- R8: The conditions rank, from highest to lowest: fault, then over-temperature, then access flash, then ready (green), then dark.
- R9: The identify lamp shows amber (both outputs 1) one clock after the request bit is high, and is dark one clock after it is low. No status input has any effect on it.
- R10: The millisecond tick comes from a counter that wraps to zero every CYC_PER_MS clock cycles. The first tick after reset falls on cycle CYC_PER_MS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_ready | input | 1 | Driver has brought the module up |
| access_stb | input | 1 | One-cycle pulse for each register access |
| over_temp | input | 1 | Over-temperature condition |
| hw_fault | input | 1 | Hardware fault detected |
| ident_req | input | 1 | Software request to light the identify lamp amber |
| stat_red | output | 1 | Status lamp, red element |
| stat_green | output | 1 | Status lamp, green element |
| ident_red | output | 1 | Identify lamp, red element |
| ident_green | output | 1 | Identify lamp, green element |

## Verification
The assertions assume that every input is synchronous to clk and stable around the sampling edge. They also assume that an access strobe may occur in any cycle, including back-to-back cycles, and that the flag inputs can change at any cycle boundary. The stimulus drives every input on the falling edge, so each value is settled before the rising edge that samples it. It raises strobes both while a flash is running and while a higher-ranked condition hides the flash. It also toggles over-temperature and fault while other conditions are active, so that every rank boundary is crossed in both directions.

// File: rtl/status_led_pkg.sv
package status_led_pkg;

    typedef enum logic [2:0] {
        MODE_DARK,
        MODE_GREEN,
        MODE_FLASH,
        MODE_BLINK,
        MODE_FAULT
    } led_mode_e;

    typedef struct packed {
        logic red;
        logic green;
    } lamp_t;

    function automatic lamp_t lamp_for_mode(led_mode_e mode, logic blink_lit);
        lamp_t l;
        l = '0;
        case (mode)
            MODE_GREEN: l.green = 1'b1;
            MODE_FLASH: begin l.red = 1'b1; l.green = 1'b1; end
            MODE_BLINK: l.red = blink_lit;
            MODE_FAULT: l.red = 1'b1;
            default:    l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/led_ms_prescaler.sv
module led_ms_prescaler #(
    parameter int unsigned CYC_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o,
    output logic [((CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1)-1:0] count_o
);
    localparam int unsigned CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/led_flash_timer.sv
module led_flash_timer #(
    parameter int unsigned FLASH_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic strike_i,
    output logic active_o,
    output logic [$clog2(FLASH_MS + 1)-1:0] left_o
);
    localparam int unsigned LW = $clog2(FLASH_MS + 1);
    localparam logic [LW-1:0] RELOAD = LW'(FLASH_MS);

    logic [LW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (strike_i)
            left_d = RELOAD;
        else if (tick_i && (left_q != '0))
            left_d = left_q - 1'b1;
        active_o = strike_i || (left_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign left_o = left_q;
endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
    parameter int unsigned HALF_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    output logic lit_o
);
    localparam int unsigned HW = (HALF_MS > 1) ? $clog2(HALF_MS) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_MS - 1);

    typedef struct packed {
        logic [HW-1:0] ms;
        logic          phase;
    } blink_s;

    blink_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (tick_i) begin
            if (s_q.ms == HALF_LAST) begin
                s_d.ms    = '0;
                s_d.phase = ~s_q.phase;
            end else begin
                s_d.ms = s_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lit_o = ~s_q.phase;
endmodule

// File: rtl/led_mode_select.sv
module led_mode_select
    import status_led_pkg::*;
(
    input  logic      ready_i,
    input  logic      flash_i,
    input  logic      hot_i,
    input  logic      fault_i,
    output led_mode_e mode_o
);
    always_comb begin
        if (fault_i)      mode_o = MODE_FAULT;
        else if (hot_i)   mode_o = MODE_BLINK;
        else if (flash_i) mode_o = MODE_FLASH;
        else if (ready_i) mode_o = MODE_GREEN;
        else              mode_o = MODE_DARK;
    end
endmodule

// File: rtl/status_led_ctrl.sv
module status_led_ctrl
    import status_led_pkg::*;
#(
    parameter int unsigned CYC_PER_MS    = 50000,
    parameter int unsigned FLASH_MS      = 50,
    parameter int unsigned BLINK_HALF_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_ready,
    input  logic access_stb,
    input  logic over_temp,
    input  logic hw_fault,
    input  logic ident_req,
    output logic stat_red,
    output logic stat_green,
    output logic ident_red,
    output logic ident_green
);
    localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int unsigned LW = $clog2(FLASH_MS + 1);

    typedef struct packed {
        lamp_t stat;
        lamp_t ident;
    } lamps_s;

    logic          ms_tick;
    logic [PW-1:0] ms_count;
    logic          flash_on;
    logic [LW-1:0] flash_left;
    logic          blink_lit;
    led_mode_e     mode;
    lamps_s        r_d, r_q;

    led_ms_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_o  (ms_tick),
        .count_o (ms_count)
    );

    led_flash_timer #(.FLASH_MS(FLASH_MS)) u_flash (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (ms_tick),
        .strike_i (access_stb),
        .active_o (flash_on),
        .left_o   (flash_left)
    );

    led_blink_timer #(.HALF_MS(BLINK_HALF_MS)) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (ms_tick),
        .run_i  (over_temp),
        .lit_o  (blink_lit)
    );

    led_mode_select u_select (
        .ready_i (drv_ready),
        .flash_i (flash_on),
        .hot_i   (over_temp),
        .fault_i (hw_fault),
        .mode_o  (mode)
    );

    always_comb begin
        r_d             = r_q;
        r_d.stat        = lamp_for_mode(mode, blink_lit);
        r_d.ident.red   = ident_req;
        r_d.ident.green = ident_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_red    = r_q.stat.red;
    assign stat_green  = r_q.stat.green;
    assign ident_red   = r_q.ident.red;
    assign ident_green = r_q.ident.green;
endmodule

// File: rtl/status_led_checks.sv
module status_led_checks #(
    parameter int unsigned CYC_PER_MS = 50000,
    parameter int unsigned FLASH_MS   = 50
) (
    input logic clk,
    input logic rst_n,
    input logic drv_ready,
    input logic access_stb,
    input logic over_temp,
    input logic hw_fault,
    input logic ident_req,
    input logic stat_red,
    input logic stat_green,
    input logic ident_red,
    input logic ident_green,
    input logic ms_tick,
    input logic [$clog2(FLASH_MS + 1)-1:0] flash_left
);
    localparam int unsigned LW = $clog2(FLASH_MS + 1);

    p_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_ready && !access_stb && flash_left == '0 && !over_temp && !hw_fault)
        |=> (!stat_red && !stat_green));

    p_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_ready && !access_stb && flash_left == '0 && !over_temp && !hw_fault)
        |=> (!stat_red && stat_green));

    p_amber_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (access_stb && !over_temp && !hw_fault) |=> (stat_red && stat_green));

    p_flash_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_stb && ms_tick && flash_left != '0)
        |=> (flash_left == $past(flash_left) - LW'(1)));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        access_stb |=> (flash_left == LW'(FLASH_MS)));

    p_blink_green_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp && !hw_fault) |=> !stat_green);

    p_blink_start_lit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(over_temp) && !hw_fault) |=> stat_red);

    p_fault_red_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_fault |=> (stat_red && !stat_green));

    p_hot_over_flash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp && access_stb && !hw_fault) |=> !stat_green);

    p_ident_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ident_req |=> (ident_red && ident_green));

    p_ident_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ident_req |=> (!ident_red && !ident_green));

    generate
        if (CYC_PER_MS > 1) begin : g_tick_gap
            p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ms_tick |=> !ms_tick);
        end
    endgenerate
endmodule

bind status_led_ctrl status_led_checks #(
    .CYC_PER_MS (CYC_PER_MS),
    .FLASH_MS   (FLASH_MS)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_ready   (drv_ready),
    .access_stb  (access_stb),
    .over_temp   (over_temp),
    .hw_fault    (hw_fault),
    .ident_req   (ident_req),
    .stat_red    (stat_red),
    .stat_green  (stat_green),
    .ident_red   (ident_red),
    .ident_green (ident_green),
    .ms_tick     (ms_tick),
    .flash_left  (flash_left)
);

// File: tb/status_led_ctrl_bench.sv
module status_led_ctrl_bench;
    localparam int CYC   = 4;
    localparam int FLASH = 50;
    localparam int HALF  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_ready = 1'b0, access_stb = 1'b0, over_temp = 1'b0;
    logic hw_fault = 1'b0, ident_req = 1'b0;
    logic stat_red, stat_green, ident_red, ident_green;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pre = 0, m_flash = 0, m_ms = 0, m_phase = 0;
    bit e_sr = 0, e_sg = 0, e_ir = 0, e_ig = 0;

    always #10 clk = ~clk;

    status_led_ctrl #(
        .CYC_PER_MS    (CYC),
        .FLASH_MS      (FLASH),
        .BLINK_HALF_MS (HALF)
    ) u_status_led_ctrl (
        .clk(clk), .rst_n(rst_n), .drv_ready(drv_ready), .access_stb(access_stb),
        .over_temp(over_temp), .hw_fault(hw_fault), .ident_req(ident_req),
        .stat_red(stat_red), .stat_green(stat_green),
        .ident_red(ident_red), .ident_green(ident_green)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_flash = 0; m_ms = 0; m_phase = 0;
            e_sr = 0; e_sg = 0; e_ir = 0; e_ig = 0;
        end else begin
            bit tick;
            bit flashing;
            tick = (m_pre == CYC - 1);
            flashing = access_stb || (m_flash > 0);
            if (hw_fault) begin e_sr = 1; e_sg = 0; end
            else if (over_temp) begin e_sr = (m_phase == 0); e_sg = 0; end
            else if (flashing) begin e_sr = 1; e_sg = 1; end
            else if (drv_ready) begin e_sr = 0; e_sg = 1; end
            else begin e_sr = 0; e_sg = 0; end
            e_ir = ident_req;
            e_ig = ident_req;
            if (access_stb) m_flash = FLASH;
            else if (tick && m_flash > 0) m_flash = m_flash - 1;
            if (!over_temp) begin m_ms = 0; m_phase = 0; end
            else if (tick) begin
                if (m_ms == HALF - 1) begin m_ms = 0; m_phase = 1 - m_phase; end
                else m_ms = m_ms + 1;
            end
            m_pre = tick ? 0 : m_pre + 1;
        end
    end

    task automatic check_bit(input string what, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check_bit("stat_red", stat_red, e_sr);
        check_bit("stat_green", stat_green, e_sg);
        check_bit("ident_red", ident_red, e_ir);
        check_bit("ident_green", ident_green, e_ig);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic strobe();
        access_stb = 1'b1;
        step(1);
        access_stb = 1'b0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check_bit("stat_red", stat_red, 1'b0);
        check_bit("stat_green", stat_green, 1'b0);
        check_bit("ident_red", ident_red, 1'b0);
        check_bit("ident_green", ident_green, 1'b0);
        rst_n = 1'b1;
        step(1);
        // R2: not yet brought up
        cur_req = "R2";
        step(20);
        // R3: ready, steady green
        cur_req = "R3";
        drv_ready = 1'b1;
        step(20);
        // R4 R10: single strobe, flash length set by the tick
        cur_req = "R4 R10";
        strobe();
        check_bit("flash_amber_R4", stat_red & stat_green, 1'b1);
        step(FLASH * CYC + 10);
        // R4: a strobe before ready still flashes
        drv_ready = 1'b0;
        strobe();
        step(FLASH * CYC + 6);
        drv_ready = 1'b1;
        // R5: restrike during flash reloads the window
        cur_req = "R5";
        strobe();
        step(100);
        strobe();
        step(FLASH * CYC - 20);
        check_bit("still_amber_R5", stat_red & stat_green, 1'b1);
        step(40);
        // R5: back-to-back strobes
        strobe(); strobe(); strobe();
        step(FLASH * CYC + 8);
        // R6 R8: over-temperature blinks, hides flash
        cur_req = "R6 R8";
        over_temp = 1'b1;
        step(1);
        check_bit("blink_starts_lit_R6", stat_red, 1'b1);
        step(HALF * CYC * 3);
        strobe();
        step(HALF * CYC);
        over_temp = 1'b0;
        step(30);
        over_temp = 1'b1;
        step(HALF * CYC + 15);
        over_temp = 1'b0;
        step(FLASH * CYC);
        // R7 R8: fault dominates everything
        cur_req = "R7 R8";
        hw_fault = 1'b1;
        step(10);
        over_temp = 1'b1;
        step(HALF * CYC * 2 + 5);
        strobe();
        step(20);
        over_temp = 1'b0;
        step(20);
        hw_fault = 1'b0;
        step(FLASH * CYC);
        // R9: identify lamp, independent of status
        cur_req = "R9";
        ident_req = 1'b1;
        step(1);
        check_bit("ident_amber_R9", ident_red & ident_green, 1'b1);
        hw_fault = 1'b1;
        step(10);
        hw_fault = 1'b0;
        over_temp = 1'b1;
        strobe();
        step(HALF * CYC + 3);
        ident_req = 1'b0;
        step(1);
        check_bit("ident_dark_R9", ident_red | ident_green, 1'b0);
        over_temp = 1'b0;
        drv_ready = 1'b0;
        step(FLASH * CYC + 5);
        // R1: reset in mid-flash
        cur_req = "R1";
        strobe();
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("stat_red_rst", stat_red, 1'b0);
        check_bit("stat_green_rst", stat_green, 1'b0);
        rst_n = 1'b1;
        step(10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule